// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Aggregator

This block merges level interrupt requests from a group of serial channels into a single level interrupt line. Each channel drives one request level. A status word records which requests are present, and bit n follows channel n. An enable mask picks the channels that may raise the output. A second mask, the wake-enable mask, is kept for a separate wake path. That mask is stored and can be read back, but it never touches the interrupt line.

Software reaches the block through a small 32-bit register port: a select, write data and a write strobe, with read data returned in the same cycle. Each mask has two addresses. Writing ones to the set address turns those mask bits on. Writing ones to the clear address turns them off. Neither needs a read-modify-write. Reading a set address returns the mask. Reading a clear address returns its bitwise inverse. The interrupt output is a register, so it changes one clock after the request or mask change that causes it, and it cannot glitch.

Top module: `irq_mask_agg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the status, enable and wake-enable registers clear to zero and `irq_o` goes low. After reset, status reads 0, both set addresses read 0, and both clear addresses read 32'hFFFFFFFF.
- R2: Status bit n equals the level that `req_i[n]` had at the previous rising edge, for every channel n below `CH_COUNT`. The status word is read at select 0, zero-extended to 32 bits.
- R3: Request inputs for channels at or above `CH_COUNT` never set a status bit and never raise `irq_o`.
- R4: A write to select 1 ORs `wdata_i[NUM_CH-1:0]` into the enable mask. A combinational read of select 1 returns the enable mask, zero-extended.
- R5: A write to select 2 clears every enable bit whose `wdata_i` bit is 1 and leaves the other bits alone. A read of select 2 returns the bitwise inverse of the zero-extended enable mask (all 32 bits).
- R6: Select 3 sets wake-enable bits and select 4 clears them, with the same OR, AND-NOT and inverted-readback rules as R4 and R5. The wake-enable mask has no effect on `irq_o`.
- R7: `irq_o` is high exactly when (status AND enable) is non-zero. It is registered and changes on the first rising edge after the request change or mask write that causes it, not before.
- R8: Writes to select 0 (status) and to the unused selects 5 to 7 change no register. The unused selects read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NUM_CH | Per-channel interrupt request levels |
| sel_i | input | 3 | Register select: 0 status, 1 enable set, 2 enable clear, 3 wake set, 4 wake clear |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe, one write per cycle in which it is high |
| rdata_o | output | 32 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Aggregated level interrupt output |

## Verification
Status bits and mask bits take a new value at the first rising edge after a request change or a write strobe. `irq_o` changes at that same edge, because it is computed from the next-state values of both registers. Read data follows the select with no clock delay. The bench drives inputs at the falling edge and checks `irq_o` again shortly after that edge, to confirm the output has not moved early. It then checks the output and the register reads at the following falling edge, one edge after the stimulus. The request sweep walks every request pattern under several enable masks. Each expected status and output is computed arithmetically from the pattern, the channel-count limit and the model masks.

// File: rtl/irq_agg_pkg.sv
// Package irq_agg_pkg
// Shared register-select encoding and helper functions for the interrupt
// mask aggregator. Assumes data words are at most 32 bits.
package irq_agg_pkg;

    localparam int SEL_W = 3;

    // Register select codes; the numbering is the software-visible address map.
    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 3'd0,
        SEL_EN_SET = 3'd1,
        SEL_EN_CLR = 3'd2,
        SEL_WK_SET = 3'd3,
        SEL_WK_CLR = 3'd4
    } reg_sel_e;

    // Returns a 32-bit word with the lowest n bits set.
    function automatic logic [31:0] low_ones(input int n);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_req_capture.sv
// Module irq_req_capture
// Samples per-channel request levels into the status register. Channels at
// or above CH_COUNT are forced to zero. Exposes the next-state value so the
// output stage can update in the same cycle as the status register.
// Assumes CH_COUNT <= NUM_CH.
module irq_req_capture #(
    parameter int NUM_CH   = 16,
    parameter int CH_COUNT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    output logic [NUM_CH-1:0] stat_d_o,
    output logic [NUM_CH-1:0] stat_q_o
);
    import irq_agg_pkg::*;

    localparam logic [31:0]       VALID_W    = low_ones(CH_COUNT);
    localparam logic [NUM_CH-1:0] VALID_MASK = VALID_W[NUM_CH-1:0];

    // One gate per channel: live channels pass, unused ones are tied off.
    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            if (VALID_MASK[g]) begin : g_live
                assign stat_d_o[g] = req_i[g];
            end else begin : g_dead
                logic unused_req;
                assign unused_req  = req_i[g];
                assign stat_d_o[g] = 1'b0;
            end
        end
    endgenerate

    // Status register: follows the gated request levels.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q_o <= '0;
        else        stat_q_o <= stat_d_o;
    end

endmodule

// File: rtl/irq_mask_reg.sv
// Module irq_mask_reg
// A mask register written only through set and clear bit vectors. Where a
// set and a clear hit the same bit in one cycle, the clear wins. Exposes the
// next-state value for single-cycle output evaluation.
module irq_mask_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_bits_i,
    input  logic [W-1:0] clr_bits_i,
    output logic [W-1:0] mask_d_o,
    output logic [W-1:0] mask_q_o
);

    // Next state: OR in the set bits, then remove the clear bits (clear priority).
    always_comb begin
        mask_d_o = (mask_q_o | set_bits_i) & ~clr_bits_i;
    end

    // Mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q_o <= '0;
        else        mask_q_o <= mask_d_o;
    end

endmodule

// File: rtl/irq_line_gen.sv
// Module irq_line_gen
// Registers the aggregated interrupt level from the next-state status and
// enable vectors, so the line changes on the same edge as those registers.
module irq_line_gen #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] stat_d_i,
    input  logic [NUM_CH-1:0] en_d_i,
    output logic              irq_o
);

    // Output flop: high when any enabled channel is requesting.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(stat_d_i & en_d_i);
    end

endmodule

// File: rtl/irq_mask_agg.sv
// Module irq_mask_agg (top)
// Merges per-channel level requests into one registered interrupt line
// under an enable mask. Also holds a wake-enable mask that only software
// sees. Register port: combinational read, one write per strobe cycle.
// Assumes 1 <= CH_COUNT <= NUM_CH <= DATA_W = 32.
module irq_mask_agg #(
    parameter int NUM_CH   = 16,
    parameter int CH_COUNT = NUM_CH,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    input  logic [2:0]        sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    import irq_agg_pkg::*;

    logic [NUM_CH-1:0] stat_d, stat_q;
    logic [NUM_CH-1:0] en_d, en_q, wake_d, wake_q;
    logic [NUM_CH-1:0] en_set, en_clr, wake_set, wake_clr;
    logic [NUM_CH-1:0] wbits;

    assign wbits = wdata_i[NUM_CH-1:0];

    // Data bits above the channel count carry no meaning.
    generate
        if (DATA_W > NUM_CH) begin : g_wide
            logic unused_wdata;
            assign unused_wdata = ^wdata_i[DATA_W-1:NUM_CH];
        end
    endgenerate

    // Write decode: turn one strobed address into set/clear vectors.
    always_comb begin
        en_set   = '0;
        en_clr   = '0;
        wake_set = '0;
        wake_clr = '0;
        if (wr_i) begin
            case (sel_i)
                SEL_EN_SET: en_set   = wbits;
                SEL_EN_CLR: en_clr   = wbits;
                SEL_WK_SET: wake_set = wbits;
                SEL_WK_CLR: wake_clr = wbits;
                default:    ;
            endcase
        end
    end

    irq_req_capture #(.NUM_CH(NUM_CH), .CH_COUNT(CH_COUNT)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .stat_d_o (stat_d),
        .stat_q_o (stat_q)
    );

    irq_mask_reg #(.W(NUM_CH)) u_enable (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_bits_i (en_set),
        .clr_bits_i (en_clr),
        .mask_d_o   (en_d),
        .mask_q_o   (en_q)
    );

    irq_mask_reg #(.W(NUM_CH)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_bits_i (wake_set),
        .clr_bits_i (wake_clr),
        .mask_d_o   (wake_d),
        .mask_q_o   (wake_q)
    );

    logic unused_wake_d;
    assign unused_wake_d = ^wake_d;

    irq_line_gen #(.NUM_CH(NUM_CH)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_d_i (stat_d),
        .en_d_i   (en_d),
        .irq_o    (irq_o)
    );

    // Zero-extended copies of the stored words for the read mux.
    logic [DATA_W-1:0] stat_w, en_w, wake_w;
    always_comb begin
        stat_w = '0;
        en_w   = '0;
        wake_w = '0;
        stat_w[NUM_CH-1:0] = stat_q;
        en_w[NUM_CH-1:0]   = en_q;
        wake_w[NUM_CH-1:0] = wake_q;
    end

    // Read mux: clear addresses return the inverted mask.
    always_comb begin
        case (sel_i)
            SEL_STATUS: rdata_o = stat_w;
            SEL_EN_SET: rdata_o = en_w;
            SEL_EN_CLR: rdata_o = ~en_w;
            SEL_WK_SET: rdata_o = wake_w;
            SEL_WK_CLR: rdata_o = ~wake_w;
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_mask_agg_chk.sv
// Module irq_mask_agg_chk
// Property checker for irq_mask_agg, attached by bind. Observes ports and
// the stored status, enable and wake-enable words.
module irq_mask_agg_chk #(
    parameter int NUM_CH   = 16,
    parameter int CH_COUNT = NUM_CH,
    parameter int DATA_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] req_i,
    input logic [2:0]        sel_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              wr_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              irq_o,
    input logic [NUM_CH-1:0] stat_q,
    input logic [NUM_CH-1:0] en_q,
    input logic [NUM_CH-1:0] wake_q
);
    import irq_agg_pkg::*;

    localparam logic [31:0]       VW   = low_ones(CH_COUNT);
    localparam logic [NUM_CH-1:0] LIVE = VW[NUM_CH-1:0];

    logic [NUM_CH-1:0] wb;
    logic [DATA_W-1:0] en_ext;
    assign wb = wdata_i[NUM_CH-1:0];
    always_comb begin
        en_ext = '0;
        en_ext[NUM_CH-1:0] = en_q;
    end

    // R1: during reset the output stays low after the first reset edge
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && stat_q == '0 && en_q == '0 && wake_q == '0));

    // R2: status tracks the previous request level
    p_stat_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat_q == ($past(req_i) & LIVE)));

    // R3: channels past the count never appear in status
    p_dead_chan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~LIVE) == '0);

    // R4: set write leaves the written bits on and keeps the old ones
    p_en_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_EN_SET) |=>
            ((en_q & ($past(wb) | $past(en_q))) == ($past(wb) | $past(en_q))));

    // R5: clear write removes the written bits
    p_en_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_EN_CLR) |=> ((en_q & $past(wb)) == '0));

    // R5: clear address reads the inverted mask
    p_clr_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SEL_EN_CLR) |-> (rdata_o == ~en_ext));

    // R6: wake set write keeps the written bits on
    p_wake_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_WK_SET) |=> ((wake_q & $past(wb)) == $past(wb)));

    // R7: the line matches the stored status and enable words
    p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(stat_q & en_q));

    // R8: no enable write strobe means no enable change
    p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && (sel_i == SEL_EN_SET || sel_i == SEL_EN_CLR)) |=> $stable(en_q));

endmodule

bind irq_mask_agg irq_mask_agg_chk #(
    .NUM_CH(NUM_CH), .CH_COUNT(CH_COUNT), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .sel_i(sel_i),
    .wdata_i(wdata_i), .wr_i(wr_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .stat_q(stat_q), .en_q(en_q), .wake_q(wake_q)
);

// File: tb/tb_irq_mask_agg.sv
// Bench for irq_mask_agg: 8 channel slots, 6 live, exhaustive request sweep.
module tb_irq_mask_agg;
    localparam int PERIOD = 10;
    localparam int NCH    = 8;
    localparam int NLIVE  = 6;
    localparam logic [NCH-1:0] LIVE = 8'h3F;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  req = '0;
    logic [2:0]      sel = 3'd0;
    logic [31:0]     wdata = '0;
    logic            wr = 1'b0;
    logic [31:0]     rdata;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NCH-1:0] m_stat = '0, m_en = '0, m_wake = '0;

    always #(PERIOD/2) clk = ~clk;

    irq_mask_agg #(.NUM_CH(NCH), .CH_COUNT(NLIVE), .DATA_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .sel_i(sel),
        .wdata_i(wdata), .wr_i(wr), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ext(input logic [NCH-1:0] v);
        return {24'h0, v};
    endfunction

    // Reads every select combinationally and compares with the model.
    task automatic read_all(input string tag);
        for (int s = 0; s < 8; s++) begin
            logic [31:0] exp;
            case (s)
                0: exp = ext(m_stat);
                1: exp = ext(m_en);
                2: exp = ~ext(m_en);
                3: exp = ext(m_wake);
                4: exp = ~ext(m_wake);
                default: exp = 32'h0;
            endcase
            sel = s[2:0];
            #1 chk(rdata, exp, $sformatf("%s sel%0d", tag, s));
        end
        sel = 3'd0;
    endtask

    // One write strobe; the model updates after the capturing edge.
    task automatic do_write(input logic [2:0] s, input logic [31:0] d);
        logic old_irq;
        @(negedge clk);
        sel = s; wdata = d; wr = 1'b1;
        old_irq = |(m_stat & m_en);
        #1 chk({31'h0, irq}, {31'h0, old_irq}, "R7 no early change on write");
        @(negedge clk);
        wr = 1'b0;
        case (s)
            3'd1: m_en   = m_en | d[NCH-1:0];
            3'd2: m_en   = m_en & ~d[NCH-1:0];
            3'd3: m_wake = m_wake | d[NCH-1:0];
            3'd4: m_wake = m_wake & ~d[NCH-1:0];
            default: ;
        endcase
        chk({31'h0, irq}, {31'h0, |(m_stat & m_en)}, "R7 irq after write");
    endtask

    // Applies one request pattern and checks the one-edge latency.
    task automatic drive_req(input logic [NCH-1:0] v, input string tag);
        logic old_irq;
        @(negedge clk);
        old_irq = |(m_stat & m_en);
        req = v;
        #1 chk({31'h0, irq}, {31'h0, old_irq}, {tag, " R7 latency"});
        @(negedge clk);
        m_stat = v & LIVE;
        sel = 3'd0;
        #1 chk(rdata, ext(m_stat), {tag, " R2/R3 status"});
        chk({31'h0, irq}, {31'h0, |(m_stat & m_en)}, {tag, " R7 irq level"});
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        req = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({31'h0, irq}, 32'h0, "R1 irq in reset");
        read_all("R1 reset");
        rst_n = 1'b1;
        req = '0;
        @(negedge clk);

        // R4/R5: set and clear through separate addresses
        do_write(3'd1, 32'h0000_0005); read_all("R4 set 05");
        do_write(3'd1, 32'hFFFF_FF30); read_all("R4 set 30");
        do_write(3'd2, 32'h0000_0011); read_all("R5 clr 11");
        do_write(3'd2, 32'hFFFF_FFFF); read_all("R5 clr all");

        // R2/R3/R7: every request pattern under several enable masks
        for (int e = 0; e < 5; e++) begin
            logic [7:0] em;
            case (e)
                0: em = 8'h00;
                1: em = 8'hFF;
                2: em = 8'h15;
                3: em = 8'h2A;
                default: em = 8'hC0;
            endcase
            do_write(3'd2, 32'hFF);
            do_write(3'd1, {24'h0, em});
            for (int v = 0; v < 256; v++) drive_req(v[7:0], "sweep");
        end

        // R6: wake mask does not disturb irq
        drive_req(8'h04, "R6 setup");
        do_write(3'd2, 32'hFF);
        do_write(3'd3, 32'h04); read_all("R6 wake set");
        chk({31'h0, irq}, 32'h0, "R6 wake no irq");
        do_write(3'd1, 32'h04);
        do_write(3'd3, 32'hFB); do_write(3'd4, 32'h0C); read_all("R6 wake clr");
        chk({31'h0, irq}, 32'h1, "R6 irq held with wake change");

        // R8: writes to status and unused selects are ignored
        do_write(3'd0, 32'hFFFF_FFFF); read_all("R8 status write");
        do_write(3'd5, 32'hFFFF_FFFF);
        do_write(3'd6, 32'h0000_0000);
        do_write(3'd7, 32'hFFFF_FFFF); read_all("R8 unused sel");

        // R1: reset after activity clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        m_stat = '0; m_en = '0; m_wake = '0;
        chk({31'h0, irq}, 32'h0, "R1 irq after re-reset");
        read_all("R1 re-reset");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule